// File: doc/BRIEF.md
# Ethernet Transmit Low-Power-Idle Controller

This block sequences the transmit side of an Energy Efficient Ethernet MAC into and out of the low-power-idle (LPI) state. Software programs a small register set: an enable, an automatic mode that waits for the transmit path to drain, an idle-timer mode that re-enters LPI after a programmed quiet period, a clock-stop enable, a link-status bit and a choice of how the sticky flags are cleared. The datapath reports through three inputs whether the transmitter is busy, whether packets are pending and whether a transmit FIFO flush was requested.

Entry is always qualified by a link-stable timer: the link-status bit must have been up for the programmed number of microsecond ticks. While in LPI the block drives `lpi_assert` so the PHY interface sends the LPI pattern, and it can raise a clock-gating request. When leaving, a wake timer counts clock cycles before the exit is reported. Sticky entry and exit flags record the transitions. All three timers share one state machine with three states: active, LPI and wake.

Top module: `eee_tx_lpi_ctrl`

## Requirements
- R1: After reset every control bit, every timer register and both flags read 0, `lpi_assert` and `clk_gate_req` are 0, and `reg_rdata` is 0.
- R2: With the automatic bit (control bit 1) clear, setting the enable (control bit 0) while the link is qualified moves the block into LPI at the next clock edge, sets the entry flag (control register bit 9), and shows the in-LPI state in control register bit 8 while `lpi_assert` is 1.
- R3: LPI is entered only when the link-status bit (control bit 4) has been 1 continuously for at least the link-stable time (register 1, bits 9:0) in ticks of TICK_DIV clock cycles.
- R4: Clearing the enable while in LPI drops `lpi_assert` at the next edge and enters the wake state; the exit flag (control register bit 10) is set after wake time (register 3, bits 15:0) plus one clock cycles in the wake state.
- R5: With the automatic bit set and the idle-timer bit (control bit 2) clear, entry waits until `tx_busy` and `tx_pending` are both 0.
- R6: With the automatic bit set and the idle-timer bit clear, `tx_busy`, `tx_pending` or `tx_flush` while in LPI starts the wake sequence and the block clears the enable bit itself.
- R7: With the automatic and idle-timer bits both set, entry requires the transmit path to be idle for the idle time (register 2, bits 19:0) in ticks; a new packet starts the wake sequence without clearing the enable, and LPI is entered again after the next idle period.
- R8: With the write-one-clear select (control bit 5) at 0, reading the control register (address 0) returns the flags and clears them; a flag event in the same cycle wins.
- R9: With the write-one-clear select at 1, reads leave the flags set and writing 1 to bit 9 or bit 10 of address 0 clears that flag.
- R10: With clock-stop enable (control bit 3) set and `rgmii_sel` low, `clk_gate_req` rises one cycle after LPI is entered and falls together with `lpi_assert`; it stays 0 when clock-stop is clear or `rgmii_sel` is 1.
- R11: When the link-status bit goes to 0, LPI or wake is left at the next edge without setting the exit flag, `clk_gate_req` drops, and the link-stable time restarts from zero.
- R12: A read request on address 0 to 3 returns the addressed register on `reg_rdata` one cycle later; `reg_rdata` holds between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 control/status, 1 link-stable time, 2 idle time, 3 wake time) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| tx_busy | input | 1 | Transmit datapath is sending |
| tx_pending | input | 1 | Packets are queued for transmission |
| tx_flush | input | 1 | Transmit FIFO flush request |
| rgmii_sel | input | 1 | Interface needs a running transmit clock |
| lpi_assert | output | 1 | Send the LPI pattern to the PHY |
| clk_gate_req | output | 1 | Transmit clock may be stopped |

## Verification
The hardest state to reach from the ports is idle-timer re-entry: the block must enter LPI, be woken by a packet without losing its enable, finish the wake count and then wait out a second idle period, all while the link-stable qualification stays met. The stimulus first qualifies the link with a short link-stable time, holds the enable with both automatic and idle-timer bits set, then pulses `tx_busy` for a few cycles and watches the block return to LPI. A behavioural model in the bench follows the prescaler, the three timers and the flags cycle by cycle, so every intermediate cycle of that sequence is compared as well as the end points.

// File: rtl/eee_lpi_pkg.sv
// Package: shared state type and register map for the transmit LPI controller.
// Assumes a 2-bit register address and the control field layout below.
package eee_lpi_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_LPI    = 2'd1,
        ST_WAKE   = 2'd2
    } lpi_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LS   = 2'd1;
    localparam logic [1:0] ADDR_IDLE = 2'd2;
    localparam logic [1:0] ADDR_WAKE = 2'd3;

    localparam int B_ENABLE = 0;
    localparam int B_AUTO   = 1;
    localparam int B_TIMER  = 2;
    localparam int B_CSTOP  = 3;
    localparam int B_LINK   = 4;
    localparam int B_W1C    = 5;
    localparam int B_STATE  = 8;
    localparam int B_ENTF   = 9;
    localparam int B_EXITF  = 10;

    typedef struct packed {
        logic w1c;
        logic link_up;
        logic clk_stop;
        logic idle_mode;
        logic auto_mode;
        logic enable;
    } lpi_ctrl_t;
endpackage

// File: rtl/eee_lpi_timers.sv
// Module: microsecond prescaler, link-stable timer and idle-entry timer.
// Assumes TICK_DIV clock cycles per microsecond tick; both timers saturate.
module eee_lpi_timers #(
    parameter int TICK_DIV = 125,
    parameter int LS_W     = 10,
    parameter int IDLE_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic [LS_W-1:0]   ls_time,
    input  logic              idle_count_en,
    input  logic [IDLE_W-1:0] idle_time,
    output logic              link_ok,
    output logic              idle_ok
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic              tick;
    logic [LS_W-1:0]   ls_cnt;
    logic [IDLE_W-1:0] idle_cnt;

    generate
        if (TICK_DIV > 1) begin : g_pre
            logic [PRE_W-1:0] pre_cnt;
            // Free-running prescaler producing one tick every TICK_DIV cycles.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pre_cnt <= '0;
                else if (pre_cnt == PRE_W'(TICK_DIV - 1))
                    pre_cnt <= '0;
                else
                    pre_cnt <= pre_cnt + 1'b1;
            end
            assign tick = (pre_cnt == PRE_W'(TICK_DIV - 1));
        end else begin : g_nopre
            assign tick = 1'b1;
        end
    endgenerate

    // Link-stable timer: restarts whenever the link bit is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ls_cnt <= '0;
        else if (!link_up)
            ls_cnt <= '0;
        else if (tick && (ls_cnt != '1))
            ls_cnt <= ls_cnt + 1'b1;
    end

    // Idle timer: counts ticks only while the path is idle and the block is active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_cnt <= '0;
        else if (!idle_count_en)
            idle_cnt <= '0;
        else if (tick && (idle_cnt != '1))
            idle_cnt <= idle_cnt + 1'b1;
    end

    assign link_ok = link_up && (ls_cnt >= ls_time);
    assign idle_ok = idle_count_en && (idle_cnt >= idle_time);

    p_ls_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (ls_cnt == '0));
endmodule

// File: rtl/eee_lpi_fsm.sv
// Module: three-state LPI sequencer (active, LPI, wake) with the wake timer.
// Assumes link_ok and idle_ok are registered-state derived and glitch free.
module eee_lpi_fsm
    import eee_lpi_pkg::*;
#(
    parameter int WAKE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              auto_mode,
    input  logic              idle_mode,
    input  logic              link_ok,
    input  logic              idle_ok,
    input  logic              tx_busy,
    input  logic              tx_pending,
    input  logic              tx_flush,
    input  logic [WAKE_W-1:0] wake_time,
    output logic              in_lpi,
    output logic              in_active,
    output logic              entry_evt,
    output logic              exit_evt,
    output logic              hw_clr_en
);
    lpi_state_e        state, state_n;
    logic [WAKE_W-1:0] wake_cnt;
    logic              wake_load, wake_inc;
    logic              path_idle, may_enter, wake_req;

    assign path_idle = !tx_busy && !tx_pending;
    assign wake_req  = tx_busy || tx_pending || tx_flush;

    // Entry policy: direct, drain-then-enter, or idle-period re-entry.
    always_comb begin
        if (!auto_mode)
            may_enter = 1'b1;
        else if (idle_mode)
            may_enter = path_idle && idle_ok;
        else
            may_enter = path_idle;
    end

    // Next-state and event decode.
    always_comb begin
        state_n   = state;
        entry_evt = 1'b0;
        exit_evt  = 1'b0;
        hw_clr_en = 1'b0;
        wake_load = 1'b0;
        wake_inc  = 1'b0;
        case (state)
            ST_ACTIVE: begin
                if (link_ok && enable && may_enter) begin
                    state_n   = ST_LPI;
                    entry_evt = 1'b1;
                end
            end
            ST_LPI: begin
                if (!link_ok) begin
                    state_n = ST_ACTIVE;
                end else if (!enable) begin
                    state_n   = ST_WAKE;
                    wake_load = 1'b1;
                end else if (auto_mode && wake_req) begin
                    state_n   = ST_WAKE;
                    wake_load = 1'b1;
                    hw_clr_en = !idle_mode;
                end
            end
            ST_WAKE: begin
                if (!link_ok) begin
                    state_n = ST_ACTIVE;
                end else if (wake_cnt == wake_time) begin
                    state_n  = ST_ACTIVE;
                    exit_evt = 1'b1;
                end else begin
                    wake_inc = 1'b1;
                end
            end
            default: state_n = ST_ACTIVE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_ACTIVE;
        else
            state <= state_n;
    end

    // Wake timer in clock cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_cnt <= '0;
        else if (wake_load)
            wake_cnt <= '0;
        else if (wake_inc)
            wake_cnt <= wake_cnt + 1'b1;
    end

    assign in_lpi    = (state == ST_LPI);
    assign in_active = (state == ST_ACTIVE);

    p_entry_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_lpi) |-> $past(link_ok));
    p_idle_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_lpi) && $past(auto_mode && idle_mode)) |-> $past(idle_ok));
    p_drain_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_lpi) && $past(auto_mode)) |-> $past(path_idle));
    p_wake_from_lpi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> ($past(state) != ST_ACTIVE));
endmodule

// File: rtl/eee_lpi_regs.sv
// Module: control/status register file with sticky flags and one-cycle reads.
// Assumes software writes take priority over the automatic enable clear.
module eee_lpi_regs
    import eee_lpi_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LS_W   = 10,
    parameter int IDLE_W = 20,
    parameter int WAKE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              in_lpi,
    input  logic              entry_evt,
    input  logic              exit_evt,
    input  logic              hw_clr_en,
    output lpi_ctrl_t         ctrl,
    output logic [LS_W-1:0]   ls_time,
    output logic [IDLE_W-1:0] idle_time,
    output logic [WAKE_W-1:0] wake_time
);
    logic              ctrl_wr, ctrl_rd;
    logic              entry_flag, exit_flag;
    logic              clr_entry, clr_exit;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wbits;

    assign ctrl_wr   = reg_wr_en && (reg_addr == ADDR_CTRL);
    assign ctrl_rd   = reg_rd_en && (reg_addr == ADDR_CTRL);
    assign clr_entry = ctrl.w1c ? (ctrl_wr && reg_wdata[B_ENTF])  : ctrl_rd;
    assign clr_exit  = ctrl.w1c ? (ctrl_wr && reg_wdata[B_EXITF]) : ctrl_rd;
    assign unused_wbits = ^reg_wdata[DATA_W-1:IDLE_W];

    // Control bits, with the hardware clear of the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.enable    <= reg_wdata[B_ENABLE];
            ctrl.auto_mode <= reg_wdata[B_AUTO];
            ctrl.idle_mode <= reg_wdata[B_TIMER];
            ctrl.clk_stop  <= reg_wdata[B_CSTOP];
            ctrl.link_up   <= reg_wdata[B_LINK];
            ctrl.w1c       <= reg_wdata[B_W1C];
        end else if (hw_clr_en) begin
            ctrl.enable <= 1'b0;
        end
    end

    // Timer limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_time   <= '0;
            idle_time <= '0;
            wake_time <= '0;
        end else if (reg_wr_en) begin
            if (reg_addr == ADDR_LS)   ls_time   <= reg_wdata[LS_W-1:0];
            if (reg_addr == ADDR_IDLE) idle_time <= reg_wdata[IDLE_W-1:0];
            if (reg_addr == ADDR_WAKE) wake_time <= reg_wdata[WAKE_W-1:0];
        end
    end

    // Sticky flags: a set event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_flag <= 1'b0;
            exit_flag  <= 1'b0;
        end else begin
            entry_flag <= entry_evt || (entry_flag && !clr_entry);
            exit_flag  <= exit_evt  || (exit_flag  && !clr_exit);
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                rd_mux[B_ENABLE] = ctrl.enable;
                rd_mux[B_AUTO]   = ctrl.auto_mode;
                rd_mux[B_TIMER]  = ctrl.idle_mode;
                rd_mux[B_CSTOP]  = ctrl.clk_stop;
                rd_mux[B_LINK]   = ctrl.link_up;
                rd_mux[B_W1C]    = ctrl.w1c;
                rd_mux[B_STATE]  = in_lpi;
                rd_mux[B_ENTF]   = entry_flag;
                rd_mux[B_EXITF]  = exit_flag;
            end
            ADDR_LS:   rd_mux[LS_W-1:0]   = ls_time;
            ADDR_IDLE: rd_mux[IDLE_W-1:0] = idle_time;
            default:   rd_mux[WAKE_W-1:0] = wake_time;
        endcase
    end

    // Read data register, one cycle latency, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd_en)
            reg_rdata <= rd_mux;
    end

    p_auto_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr_en && !ctrl_wr) |=> !ctrl.enable);
    p_w1c_read_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_flag && ctrl.w1c && !ctrl_wr) |=> entry_flag);
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !ctrl.w1c && !exit_evt) |=> !exit_flag);
    p_exit_needs_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exit_flag) |-> $past(exit_evt));
endmodule

// File: rtl/eee_tx_lpi_ctrl.sv
// Module: top of the transmit LPI controller; wires registers, timers and
// sequencer and registers the clock-gating request.
// Assumes all inputs are synchronous to clk.
module eee_tx_lpi_ctrl
    import eee_lpi_pkg::*;
#(
    parameter int TICK_DIV = 125,
    parameter int DATA_W   = 32,
    parameter int LS_W     = 10,
    parameter int IDLE_W   = 20,
    parameter int WAKE_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_busy,
    input  logic              tx_pending,
    input  logic              tx_flush,
    input  logic              rgmii_sel,
    output logic              lpi_assert,
    output logic              clk_gate_req
);
    lpi_ctrl_t         ctrl;
    logic [LS_W-1:0]   ls_time;
    logic [IDLE_W-1:0] idle_time;
    logic [WAKE_W-1:0] wake_time;
    logic in_lpi, in_active, entry_evt, exit_evt, hw_clr_en;
    logic link_ok, idle_ok, idle_count_en, gate_q;

    assign idle_count_en = in_active && !tx_busy && !tx_pending;

    eee_lpi_regs #(.DATA_W(DATA_W), .LS_W(LS_W), .IDLE_W(IDLE_W), .WAKE_W(WAKE_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_lpi(in_lpi), .entry_evt(entry_evt), .exit_evt(exit_evt),
        .hw_clr_en(hw_clr_en), .ctrl(ctrl),
        .ls_time(ls_time), .idle_time(idle_time), .wake_time(wake_time)
    );

    eee_lpi_timers #(.TICK_DIV(TICK_DIV), .LS_W(LS_W), .IDLE_W(IDLE_W)) timers_i (
        .clk(clk), .rst_n(rst_n),
        .link_up(ctrl.link_up), .ls_time(ls_time),
        .idle_count_en(idle_count_en), .idle_time(idle_time),
        .link_ok(link_ok), .idle_ok(idle_ok)
    );

    eee_lpi_fsm #(.WAKE_W(WAKE_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .enable(ctrl.enable), .auto_mode(ctrl.auto_mode), .idle_mode(ctrl.idle_mode),
        .link_ok(link_ok), .idle_ok(idle_ok),
        .tx_busy(tx_busy), .tx_pending(tx_pending), .tx_flush(tx_flush),
        .wake_time(wake_time),
        .in_lpi(in_lpi), .in_active(in_active),
        .entry_evt(entry_evt), .exit_evt(exit_evt), .hw_clr_en(hw_clr_en)
    );

    // Clock-gating request registered one cycle after LPI is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else
            gate_q <= in_lpi && ctrl.clk_stop && !rgmii_sel;
    end

    assign lpi_assert   = in_lpi;
    assign clk_gate_req = gate_q && in_lpi;

    p_gate_needs_cstop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate_req |-> $past(ctrl.clk_stop && !rgmii_sel));
    p_link_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.link_up |=> !lpi_assert);
    p_entry_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpi_assert) |-> $past(entry_evt));
endmodule

// File: tb/eee_tx_lpi_ctrl_tb_top.sv
// Bench: behavioural cycle model compared every clock plus directed checks.
module eee_tx_lpi_ctrl_tb_top;
    localparam int DIV = 4;
    localparam int EN = 1, AUTO = 2, TMR = 4, CS = 8, LINK = 16, W1C = 32;
    localparam int STB = 256, ENTB = 512, EXB = 1024;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, rd_en = 0, busy = 0, pend = 0, flush = 0, rgmii = 0;
    logic [1:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic lpi, gate;

    int errors = 0, checks = 0, cycles = 0;

    eee_tx_lpi_ctrl #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .tx_busy(busy), .tx_pending(pend), .tx_flush(flush), .rgmii_sel(rgmii),
        .lpi_assert(lpi), .clk_gate_req(gate)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Behavioural model state.
    int m_ctrl, m_ls, m_idle, m_wake, m_st, m_pre, m_lsc, m_ic, m_wc;
    int m_entf, m_exf, m_gq, m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_ls = 0; m_idle = 0; m_wake = 0; m_st = 0; m_pre = 0;
            m_lsc = 0; m_ic = 0; m_wc = 0; m_entf = 0; m_exf = 0; m_gq = 0; m_rd = 0;
        end else begin
            bit tick, lok, iok, pidle, go, ent, ex, hw, linkb, w1c, clr_en, clr_ex;
            int ns, sel;
            tick  = (m_pre == DIV - 1);
            linkb = (m_ctrl & LINK) != 0;
            w1c   = (m_ctrl & W1C) != 0;
            lok   = linkb && (m_lsc >= m_ls);
            pidle = !busy && !pend;
            iok   = (m_st == 0) && pidle && (m_ic >= m_idle);
            ns = m_st; ent = 0; ex = 0; hw = 0;
            if (m_st == 0) begin
                if ((m_ctrl & AUTO) == 0) go = 1;
                else if ((m_ctrl & TMR) != 0) go = pidle && iok;
                else go = pidle;
                if (lok && (m_ctrl & EN) != 0 && go) begin ns = 1; ent = 1; end
            end else if (m_st == 1) begin
                if (!lok) ns = 0;
                else if ((m_ctrl & EN) == 0) ns = 2;
                else if ((m_ctrl & AUTO) != 0 && (busy || pend || flush)) begin
                    ns = 2; hw = (m_ctrl & TMR) == 0;
                end
            end else begin
                if (!lok) ns = 0;
                else if (m_wc == m_wake) begin ns = 0; ex = 1; end
            end
            if (m_st != 2 && ns == 2) m_wc = 0;
            else if (m_st == 2 && ns == 2) m_wc++;
            if (!linkb) m_lsc = 0; else if (tick && m_lsc < 1023) m_lsc++;
            if (m_st == 0 && pidle) begin
                if (tick && m_ic < (1 << 20) - 1) m_ic++;
            end else m_ic = 0;
            m_gq = (m_st == 1) && (m_ctrl & CS) != 0 && !rgmii;
            sel = (addr == 0);
            if (rd_en) begin
                case (addr)
                    0: m_rd = (m_ctrl & 63) | ((m_st == 1) ? STB : 0) |
                              (m_entf ? ENTB : 0) | (m_exf ? EXB : 0);
                    1: m_rd = m_ls;
                    2: m_rd = m_idle;
                    default: m_rd = m_wake;
                endcase
            end
            clr_en = w1c ? (wr_en && sel && wdata[9])  : (rd_en && sel);
            clr_ex = w1c ? (wr_en && sel && wdata[10]) : (rd_en && sel);
            m_entf = ent || (m_entf && !clr_en);
            m_exf  = ex  || (m_exf && !clr_ex);
            if (wr_en) begin
                case (addr)
                    0: m_ctrl = int'(wdata) & 63;
                    1: m_ls = int'(wdata) & 1023;
                    2: m_idle = int'(wdata) & ((1 << 20) - 1);
                    default: m_wake = int'(wdata) & 65535;
                endcase
            end else if (hw) m_ctrl = m_ctrl & ~EN;
            m_pre = tick ? 0 : m_pre + 1;
            m_st = ns;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(lpi == (m_st == 1), "R2 model lpi_assert", int'(lpi), int'(m_st == 1));
            chk(gate == (m_gq != 0 && m_st == 1), "R10 model clk_gate_req", int'(gate),
                int'(m_gq != 0 && m_st == 1));
            chk(rdata == m_rd[31:0], "R12 model reg_rdata", int'(rdata), m_rd);
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(posedge clk); #1;
        rd_en = 1; addr = a;
        @(posedge clk); #1;
        rd_en = 0;
        @(negedge clk);
        v = int'(rdata);
    endtask

    initial begin
        int c, v;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(lpi == 0 && gate == 0, "R1 outputs after reset", int'({lpi, gate}), 0);
        chk(rdata == 0, "R1 rdata after reset", int'(rdata), 0);
        rd(0, v); chk(v == 0, "R1 control reset", v, 0);
        rd(3, v); chk(v == 0, "R1 wake reset", v, 0);

        wr(1, 3); wr(2, 2); wr(3, 2);
        rd(1, v); chk(v == 3, "R12 link-stable readback", v, 3);
        rd(2, v); chk(v == 2, "R12 idle readback", v, 2);

        c = LINK | EN; wr(0, c);
        step(2); chk(lpi == 0, "R3 no LPI before link stable", int'(lpi), 0);
        step(30); chk(lpi == 1, "R2 direct entry", int'(lpi), 1);
        rd(0, v); chk(v == (c | STB | ENTB), "R8 entry flag and state", v, c | STB | ENTB);
        rd(0, v); chk(v == (c | STB), "R8 read cleared entry flag", v, c | STB);

        c = c & ~EN; wr(0, c);
        step(1); chk(lpi == 0, "R4 exit drops lpi", int'(lpi), 0);
        step(10); rd(0, v); chk(v == (c | EXB), "R4 exit flag after wake", v, c | EXB);
        rd(0, v); chk(v == c, "R8 exit flag cleared", v, c);

        busy = 1; c = c | AUTO | EN; wr(0, c);
        step(30); chk(lpi == 0, "R5 held off while busy", int'(lpi), 0);
        busy = 0; pend = 1;
        step(30); chk(lpi == 0, "R5 held off while pending", int'(lpi), 0);
        pend = 0;
        step(5); chk(lpi == 1, "R5 entry after drain", int'(lpi), 1);
        rd(0, v);
        pend = 1; step(3); pend = 0;
        chk(lpi == 0, "R6 packet wakes", int'(lpi), 0);
        c = c & ~EN;
        step(10); rd(0, v); chk(v == (c | EXB), "R6 enable auto-cleared", v, c | EXB);

        wr(0, c | EN);
        step(5); chk(lpi == 1, "R6 re-entry before flush", int'(lpi), 1);
        flush = 1; step(1); flush = 0;
        step(10); chk(lpi == 0, "R6 flush wakes", int'(lpi), 0);
        rd(0, v); chk(v == (c | ENTB | EXB), "R6 flush clears enable", v, c | ENTB | EXB);

        c = c | EN | TMR; wr(0, c);
        step(30); chk(lpi == 1, "R7 idle-timer entry", int'(lpi), 1);
        busy = 1; step(3);
        chk(lpi == 0, "R7 packet wakes", int'(lpi), 0);
        busy = 0;
        rd(0, v); chk((v & EN) != 0, "R7 enable kept", v & EN, EN);
        step(30); chk(lpi == 1, "R7 re-entry after idle", int'(lpi), 1);

        c = c | CS; wr(0, c);
        step(3); chk(gate == 1, "R10 gate request in LPI", int'(gate), 1);
        rgmii = 1; step(3); chk(gate == 0, "R10 gate blocked by rgmii", int'(gate), 0);
        rgmii = 0; step(3); chk(gate == 1, "R10 gate restored", int'(gate), 1);

        rd(0, v);
        c = c & ~LINK; wr(0, c);
        step(1); chk(lpi == 0 && gate == 0, "R11 link down abandons LPI", int'({lpi, gate}), 0);
        step(10); rd(0, v); chk((v & EXB) == 0, "R11 no exit flag", v & EXB, 0);
        c = c | LINK; wr(0, c);
        step(2); chk(lpi == 0, "R11 link-stable restarts", int'(lpi), 0);

        c = c | W1C; wr(0, c);
        step(30); chk(lpi == 1, "R9 entered again", int'(lpi), 1);
        rd(0, v); rd(0, v); chk((v & ENTB) != 0, "R9 read keeps flag", v & ENTB, ENTB);
        wr(0, c | ENTB);
        rd(0, v); chk((v & ENTB) == 0, "R9 write one clears", v & ENTB, 0);

        step(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule